// File: doc/BRIEF.md
# Prescaled 16-bit Up-Counter with Overflow Flags

This block is a free-running 16-bit timer/counter that software can only observe, never write. Its count events come from one of three places, chosen by a two-bit configuration field: an internal tick that fires once every twelve system clocks, rising edges on an external count pin, or nothing at all. The chosen events first pass through a prescaler that divides them by 1, 2, 4 or 8. Each prescaler output step adds one to the counter.

Whenever the source or the division factor changes, the prescaler (and the internal tick divider) return to zero. This means a new setting always starts from a clean phase. The counter is cleared by the system reset. It is also cleared by a rising edge on an external reset pin when that path is enabled. A low-power halt input clears the counter and prescaler and holds them at zero for as long as it is asserted.

Two sticky interrupt flags are produced. One is set when the low byte wraps and the other when the full 16-bit value wraps. Each is cleared by its own one-cycle clear pulse. The count is presented as two byte-wide halves taken straight from the counter register with no shadow copy. A reader that samples the two halves at different times across a carry can therefore see a torn value.

Top module: `tmr16_prescaled`

## Requirements
- R1: After reset the count reads 0 and both overflow flags read 0.
- R2: Source code 2'd1 selects the internal tick, 2'd2 selects the external count pin, and 2'd0 and 2'd3 select no source; with no source selected the count does not change.
- R3: The internal tick occurs once every 12 system clocks, so with division code 0 the count advances by one per 12 clocks.
- R4: Division code 0, 1, 2, 3 makes the counter advance once per 1, 2, 4, 8 selected events respectively.
- R5: Any change of the source code or the division code clears the prescaler, and no count step occurs in the cycle the change is seen.
- R6: With the external-reset enable at 1, a rising edge on the external reset pin clears the counter and the prescaler; with the enable at 0 such an edge has no effect.
- R7: While halt is 1 the count is 0 and stays 0 whatever events arrive, and the prescaler is cleared.
- R8: The low-byte flag sets when a step takes the low byte from 8'hFF to 8'h00; the full flag sets when a step takes the count from 16'hFFFF to 16'h0000.
- R9: Each flag stays set until its own clear input is 1 for a cycle; a clear does not affect the other flag; when a set and a clear of the same flag fall in one cycle, the flag ends up set.
- R10: The external pins are synchronised through two flops; each rising edge of the external count pin yields exactly one event, and events are at least two system clocks apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| src_sel | input | 2 | Event source: 1 internal /12 tick, 2 external pin, 0 or 3 none |
| div_sel | input | 2 | Prescaler division: 0→/1, 1→/2, 2→/4, 3→/8 |
| ext_rst_en | input | 1 | Enables clearing by the external reset pin |
| halt | input | 1 | Low-power halt: clears and holds counter and prescaler |
| ext_cnt_pin | input | 1 | Asynchronous external count input, rising edges counted |
| ext_rst_pin | input | 1 | Asynchronous external reset input, rising edge clears |
| ovf_lo_clr | input | 1 | One-cycle clear of the low-byte overflow flag |
| ovf_full_clr | input | 1 | One-cycle clear of the 16-bit overflow flag |
| cnt_lo | output | 8 | Low byte of the count |
| cnt_hi | output | 8 | High byte of the count |
| ovf_lo_flag | output | 1 | Sticky low-byte overflow flag |
| ovf_full_flag | output | 1 | Sticky 16-bit overflow flag |

## Verification
Several properties are checked in every cycle: the count only holds, steps by one or falls to zero; halt and an enabled external reset edge leave the count at zero; the flags set on their wraps and stay set without a clear; configuration changes never coincide with a step; and detected external edges never come in adjacent cycles. Other behaviour needs the bench's scenarios to show it. This covers the exact division ratios, the twelve-clock tick period, the lost phase after a configuration change, the disabled external reset being ignored, and the set-beats-clear timing, because each of these depends on the number of events seen over many cycles.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;

    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_TICK  = 2'd1,
        SRC_PIN   = 2'd2,
        SRC_NONE2 = 2'd3
    } src_e;

    // Terminal prescaler value for a division code: 0,1,3,7
    function automatic logic [2:0] div_limit(input logic [1:0] code);
        return (3'd1 << code) - 3'd1;
    endfunction

endpackage

// File: rtl/tmr_edge_sync.sv
`timescale 1ns/1ps
module tmr_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic rise_o
);
    localparam int SW = STAGES + 1;

    typedef struct packed {
        logic [SW-1:0] sh;
    } st_t;

    st_t q, d;

    always_comb begin
        d      = q;
        d.sh   = {q.sh[SW-2:0], pin_i};
        rise_o = q.sh[STAGES-1] & ~q.sh[STAGES];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R10: a detected edge is never followed by another in the next cycle
    a_r10_rise_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);

endmodule

// File: rtl/tmr_prescaler.sv
`timescale 1ns/1ps
module tmr_prescaler
    import tmr_pkg::*;
#(
    parameter int TICK_DIV = 12,
    parameter int PS_W     = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] src_i,
    input  logic [1:0] div_i,
    input  logic       pin_rise_i,
    input  logic       clr_i,
    output logic       step_o
);
    localparam int TW = $clog2(TICK_DIV);

    typedef struct packed {
        logic [TW-1:0]   tick_cnt;
        logic [PS_W-1:0] ps;
        logic [1:0]      src;
        logic [1:0]      div;
    } st_t;

    st_t q, d;

    logic            cfg_chg;
    logic            tick;
    logic            ev;
    logic [PS_W-1:0] lim;

    always_comb begin
        d       = q;
        cfg_chg = (src_i != q.src) || (div_i != q.div);
        tick    = (q.tick_cnt == TW'(TICK_DIV - 1));
        ev      = ((src_i == SRC_TICK) && tick) || ((src_i == SRC_PIN) && pin_rise_i);
        lim     = PS_W'(div_limit(div_i));
        step_o  = ev && !cfg_chg && !clr_i && (q.ps == lim);

        d.tick_cnt = tick ? '0 : q.tick_cnt + TW'(1);
        if (ev) d.ps = (q.ps == lim) ? '0 : q.ps + PS_W'(1);
        if (cfg_chg || clr_i) begin
            d.tick_cnt = '0;
            d.ps       = '0;
        end
        d.src = src_i;
        d.div = div_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R5: a configuration change is never accompanied by a count step
    a_r5_no_step_on_change: assert property (@(posedge clk) disable iff (!rst_n)
        ((src_i != q.src) || (div_i != q.div)) |-> !step_o);

    // R7: clearing forces the prescaler phase back to zero
    a_r7_clr_resets_phase: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (q.ps == '0));

endmodule

// File: rtl/tmr_count16.sv
`timescale 1ns/1ps
module tmr_count16 #(
    parameter int CNT_W = 16,
    parameter int LO_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    input  logic             clr_i,
    input  logic             lo_clr_i,
    input  logic             full_clr_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             ovf_lo_o,
    output logic             ovf_full_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             ovf_lo;
        logic             ovf_full;
    } st_t;

    st_t  q, d;
    logic set_lo, set_full;

    always_comb begin
        d        = q;
        set_lo   = step_i && !clr_i && (q.cnt[LO_W-1:0] == '1);
        set_full = step_i && !clr_i && (q.cnt == '1);

        if (clr_i)       d.cnt = '0;
        else if (step_i) d.cnt = q.cnt + CNT_W'(1);

        if (lo_clr_i)   d.ovf_lo   = 1'b0;
        if (set_lo)     d.ovf_lo   = 1'b1;
        if (full_clr_i) d.ovf_full = 1'b0;
        if (set_full)   d.ovf_full = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cnt_o      = q.cnt;
    assign ovf_lo_o   = q.ovf_lo;
    assign ovf_full_o = q.ovf_full;

    // R2: the count holds, steps by one, or drops to zero
    a_r2_step_shape: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (cnt_o == $past(cnt_o) || cnt_o == $past(cnt_o) + CNT_W'(1) || cnt_o == '0));

    // R8: low byte wrap raises the low flag
    a_r8_lo_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !clr_i && cnt_o[LO_W-1:0] == '1) |=> ovf_lo_o);

    // R8: full wrap raises the full flag and leaves zero
    a_r8_full_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !clr_i && cnt_o == '1) |=> (ovf_full_o && cnt_o == '0));

    // R9: flags are sticky without a clear
    a_r9_lo_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_lo_o && !lo_clr_i) |=> ovf_lo_o);
    a_r9_full_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_full_o && !full_clr_i) |=> ovf_full_o);

endmodule

// File: rtl/tmr16_prescaled.sv
`timescale 1ns/1ps
module tmr16_prescaled
    import tmr_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int TICK_DIV = 12,
    parameter int SYNC_N   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         src_sel,
    input  logic [1:0]         div_sel,
    input  logic               ext_rst_en,
    input  logic               halt,
    input  logic               ext_cnt_pin,
    input  logic               ext_rst_pin,
    input  logic               ovf_lo_clr,
    input  logic               ovf_full_clr,
    output logic [CNT_W/2-1:0] cnt_lo,
    output logic [CNT_W/2-1:0] cnt_hi,
    output logic               ovf_lo_flag,
    output logic               ovf_full_flag
);
    localparam int HALF = CNT_W / 2;

    logic             cnt_rise, rst_rise;
    logic             step, cnt_clr;
    logic [CNT_W-1:0] count;

    tmr_edge_sync #(.STAGES(SYNC_N)) u_cnt_sync (
        .clk(clk), .rst_n(rst_n), .pin_i(ext_cnt_pin), .rise_o(cnt_rise));

    tmr_edge_sync #(.STAGES(SYNC_N)) u_rst_sync (
        .clk(clk), .rst_n(rst_n), .pin_i(ext_rst_pin), .rise_o(rst_rise));

    assign cnt_clr = halt || (ext_rst_en && rst_rise);

    tmr_prescaler #(.TICK_DIV(TICK_DIV), .PS_W(3)) u_ps (
        .clk(clk), .rst_n(rst_n), .src_i(src_sel), .div_i(div_sel),
        .pin_rise_i(cnt_rise), .clr_i(cnt_clr), .step_o(step));

    tmr_count16 #(.CNT_W(CNT_W), .LO_W(HALF)) u_cnt (
        .clk(clk), .rst_n(rst_n), .step_i(step), .clr_i(cnt_clr),
        .lo_clr_i(ovf_lo_clr), .full_clr_i(ovf_full_clr),
        .cnt_o(count), .ovf_lo_o(ovf_lo_flag), .ovf_full_o(ovf_full_flag));

    assign cnt_lo = count[HALF-1:0];
    assign cnt_hi = count[CNT_W-1:HALF];

    // R7: halt leaves the count at zero
    a_r7_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> ({cnt_hi, cnt_lo} == '0));

    // R6: an enabled external reset edge clears the count
    a_r6_ext_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_rst_en && rst_rise) |=> ({cnt_hi, cnt_lo} == '0));

endmodule

// File: tb/tmr16_prescaled_test.sv
`timescale 1ns/1ps
module tmr16_prescaled_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] src_sel = 2'd0;
    logic [1:0] div_sel = 2'd0;
    logic       ext_rst_en = 1'b0;
    logic       halt = 1'b0;
    logic       ext_cnt_pin = 1'b0;
    logic       ext_rst_pin = 1'b0;
    logic       ovf_lo_clr = 1'b0;
    logic       ovf_full_clr = 1'b0;
    logic [7:0] cnt_lo, cnt_hi;
    logic       ovf_lo_flag, ovf_full_flag;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #4 clk = ~clk;

    tmr16_prescaled uut (
        .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .div_sel(div_sel),
        .ext_rst_en(ext_rst_en), .halt(halt), .ext_cnt_pin(ext_cnt_pin),
        .ext_rst_pin(ext_rst_pin), .ovf_lo_clr(ovf_lo_clr), .ovf_full_clr(ovf_full_clr),
        .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .ovf_lo_flag(ovf_lo_flag),
        .ovf_full_flag(ovf_full_flag));

    // vector: {src[27:26], div[25:24], pulses[23:16], expected count[15:0]}
    localparam int NV = 7;
    localparam logic [27:0] VEC [NV] = '{
        {2'd2, 2'd0, 8'd10, 16'd10},   // R4 /1
        {2'd2, 2'd1, 8'd10, 16'd5},    // R4 /2
        {2'd2, 2'd2, 8'd11, 16'd2},    // R4 /4
        {2'd2, 2'd3, 8'd17, 16'd2},    // R4 /8
        {2'd0, 2'd0, 8'd9,  16'd0},    // R2 no source
        {2'd3, 2'd0, 8'd9,  16'd0},    // R2 no source, alt code
        {2'd2, 2'd0, 8'd1,  16'd1}     // R10 single edge
    };

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int count();
        return {cnt_hi, cnt_lo};
    endfunction

    task automatic clocks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_slow(input int n);
        for (int i = 0; i < n; i++) begin
            ext_cnt_pin = 1'b1; clocks(2);
            ext_cnt_pin = 1'b0; clocks(2);
        end
        clocks(6);
    endtask

    task automatic pulse_fast(input int n);
        for (int i = 0; i < n; i++) begin
            ext_cnt_pin = 1'b1; clocks(1);
            ext_cnt_pin = 1'b0; clocks(1);
        end
        clocks(6);
    endtask

    task automatic rst_pulse();
        ext_rst_pin = 1'b1; clocks(2);
        ext_rst_pin = 1'b0; clocks(6);
    endtask

    task automatic restart(input logic [1:0] s, input logic [1:0] dv);
        halt = 1'b1; clocks(2);
        src_sel = s; div_sel = dv; clocks(2);
        halt = 1'b0; clocks(1);
    endtask

    initial begin
        clocks(3);
        rst_n = 1'b1;
        clocks(2);
        // R1 reset state
        check("R1 count", count(), 0);
        check("R1 low flag", ovf_lo_flag, 0);
        check("R1 full flag", ovf_full_flag, 0);

        for (int v = 0; v < NV; v++) begin
            restart(VEC[v][27:26], VEC[v][25:24]);
            pulse_slow(int'(VEC[v][23:16]));
            check($sformatf("R4/R2/R10 vector %0d", v), count(), int'(VEC[v][15:0]));
        end

        // R3 internal tick, /1 and /2
        restart(2'd1, 2'd0);
        clocks(12 * 20 + 5);
        check("R3 tick /1", count(), 20);
        restart(2'd1, 2'd1);
        clocks(24 * 10 + 5);
        check("R3 tick /2", count(), 10);
        // R2 external pulses ignored when the tick is selected
        restart(2'd1, 2'd3);
        pulse_fast(5);
        check("R2 pin ignored on tick source", count(), 0);

        // R5 configuration change clears the prescaler
        restart(2'd2, 2'd2);
        pulse_slow(3);
        check("R5 before change", count(), 0);
        src_sel = 2'd0; clocks(2);
        src_sel = 2'd2; clocks(2);
        pulse_slow(1);
        check("R5 phase lost", count(), 0);
        pulse_slow(3);
        check("R5 fresh phase", count(), 1);

        // R6 external reset
        restart(2'd2, 2'd0);
        pulse_slow(5);
        ext_rst_en = 1'b0;
        rst_pulse();
        check("R6 disabled reset ignored", count(), 5);
        ext_rst_en = 1'b1;
        rst_pulse();
        check("R6 enabled reset clears", count(), 0);
        div_sel = 2'd2; clocks(2);
        pulse_slow(3);
        rst_pulse();
        pulse_slow(3);
        check("R6 reset clears prescaler", count(), 0);
        ext_rst_en = 1'b0;

        // R7 halt
        restart(2'd2, 2'd0);
        pulse_slow(4);
        halt = 1'b1; clocks(2);
        check("R7 halt clears", count(), 0);
        pulse_slow(5);
        check("R7 halt holds", count(), 0);
        halt = 1'b0; clocks(1);

        // R8/R9 overflow flags
        restart(2'd2, 2'd0);
        ovf_lo_clr = 1'b1; ovf_full_clr = 1'b1; clocks(1);
        ovf_lo_clr = 1'b0; ovf_full_clr = 1'b0; clocks(1);
        pulse_fast(255);
        check("R8 count 255", count(), 255);
        check("R8 low flag not yet", ovf_lo_flag, 0);
        // R9 set and clear in the same cycle: set wins
        ext_cnt_pin = 1'b1; clocks(1);
        ext_cnt_pin = 1'b0; clocks(1);
        ovf_lo_clr = 1'b1; clocks(1);
        ovf_lo_clr = 1'b0;
        check("R9 set wins over clear", ovf_lo_flag, 1);
        check("R8 count 256", count(), 256);
        clocks(2);
        check("R9 low flag sticky", ovf_lo_flag, 1);
        ovf_lo_clr = 1'b1; clocks(1);
        ovf_lo_clr = 1'b0; clocks(1);
        check("R9 low flag cleared", ovf_lo_flag, 0);
        pulse_fast(65535 - 256);
        check("R8 count FFFF", count(), 65535);
        check("R8 full flag not yet", ovf_full_flag, 0);
        pulse_fast(1);
        check("R8 wrap to zero", count(), 0);
        check("R8 full flag set", ovf_full_flag, 1);
        check("R8 low flag set on wrap", ovf_lo_flag, 1);
        ovf_full_clr = 1'b1; clocks(1);
        ovf_full_clr = 1'b0; clocks(1);
        check("R9 full flag cleared", ovf_full_flag, 0);
        check("R9 low flag untouched", ovf_lo_flag, 1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule